// File: doc/BRIEF.md
# Dual-Channel Converter Bus Write Sequencer

This block sits on the host side of a byte-wide parallel bus. It drives a dual 12-bit converter that has two load stages per channel, so data is written first into holding registers and then moved into the output registers. One accepted request carries two channel codes. The sequencer turns that request into four byte writes followed by one transfer strobe that updates both channels at the same instant. A request can instead ask for a clear, which produces one long pulse on the active-low clear line.

All bus timing comes from the system clock. Each nanosecond minimum (address setup and hold, data setup and hold, write pulse width, clear pulse width) is converted at elaboration time into a whole number of clock cycles, rounded up, and every phase lasts exactly that many cycles. The request side uses a valid/ready handshake, and completion is reported with a one-cycle done pulse.

Top module: `dac_bus_sequencer`

## Requirements
- R1: During and right after reset, the block is idle. In that state chip select, write, update and clear are all high, the address and data are zero, ready is high and done is low.
- R2: Ready is high only while the sequencer is idle, and every strobe is inactive whenever ready is high. A request is taken on a clock edge where valid and ready are both high. Ready then stays low until the cycle after done.
- R3: A load request produces four writes with chip select low, in this order: address 0 carries the low byte of channel A, address 1 the high part of channel A, address 2 the low byte of channel B, address 3 the high part of channel B. Address bit 1 selects the channel and address bit 0 selects the high part.
- R4: On a high-part write (address bit 0 = 1) the upper channel bits appear on data bits 3..0, and data bits 7..4 are driven to zero.
- R5: During each write, address, data and chip select are stable for exactly SU cycles before write falls. Write stays low for PW cycles with address and data unchanged. Address, data and chip select are then held for HD cycles after write rises.
- R6: After the fourth write comes one transfer strobe. Chip select stays high, and update is low for exactly the cycles in which write is low (PW cycles), with the same SU and HD spacing around it. Chip select and update are never low together.
- R7: Done pulses high for exactly one cycle. For a load it comes 5·(SU+PW+HD) cycles after the first setup cycle; for a clear it comes CL cycles after. Ready is high in the cycle after done.
- R8: A clear request drives clear low for CL cycles, with chip select, write and update all high. It then reports done, and the request's channel codes are ignored.
- R9: Each count is ceil(ns·1000 / clock period in ps), with a minimum of 1. SU comes from address setup and HD from the larger of the address hold and data hold. PW is the larger of the write pulse count and (data setup count − SU), and CL comes from the clear pulse. At a 10 ns clock: SU=2, PW=8, HD=3, CL=8.
- R10: A request held valid while the sequencer is busy has no effect on the bus. Changing its channel codes in that time also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_clear | input | 1 | 1 = clear request, 0 = load request |
| req_ch_a | input | CHAN_W | Code for channel A |
| req_ch_b | input | CHAN_W | Code for channel B |
| done | output | 1 | One-cycle completion pulse |
| bus_addr | output | 2 | Holding-register select |
| bus_data | output | BUS_W | Byte lane to the converter |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_upd_n | output | 1 | Active-low transfer strobe |
| bus_clr_n | output | 1 | Active-low clear |

## Verification
Two events can land in the same cycle: the done pulse of one transaction and a request that has been held valid the whole time the sequencer was busy. The bench keeps valid high, with changed codes, from the accept edge until done. It then drops valid in the done cycle. The scoreboard treats any bus strobe it did not expect as a failure, and the bench checks that the bus stays idle afterwards. A second overlap is a clear followed at once by a load. Here the bench confirms that the clear pulse and the first write setup never share a cycle, and that each starts with its full count.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_PULSE,
      ST_HOLD,
      ST_CLEAR,
      ST_DONE
   } seq_state_e;

   localparam int unsigned STEP_W   = 3;
   localparam int unsigned UPD_STEP = 4;

   // Round a nanosecond minimum up to whole clock cycles, never below one.
   function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                input int unsigned period_ps);
      int unsigned c;
      c = (ns * 1000 + period_ps - 1) / period_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dac_seq_phase_timer.sv
module dac_seq_phase_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/dac_seq_byte_lane.sv
module dac_seq_byte_lane #(
   parameter int unsigned CHAN_W = 12,
   parameter int unsigned BUS_W  = 8
) (
   input  logic [CHAN_W-1:0] ch_a,
   input  logic [CHAN_W-1:0] ch_b,
   input  logic [1:0]        sel,
   output logic [BUS_W-1:0]  lane
);
   localparam int unsigned HI_W = CHAN_W - BUS_W;

   logic [BUS_W-1:0] part [4];

   for (genvar c = 0; c < 2; c++) begin : g_chan
      logic [CHAN_W-1:0] src;
      assign src = (c == 0) ? ch_a : ch_b;
      assign part[2*c] = src[BUS_W-1:0];
      if (HI_W == BUS_W) begin : g_full
         assign part[2*c+1] = src[CHAN_W-1:BUS_W];
      end else begin : g_pad
         assign part[2*c+1] = {{(BUS_W-HI_W){1'b0}}, src[CHAN_W-1:BUS_W]};
      end
   end

   assign lane = part[sel];
endmodule

// File: rtl/dac_seq_strobe_decode.sv
module dac_seq_strobe_decode
   import dac_seq_pkg::*;
#(
   parameter int unsigned BUS_W = 8
) (
   input  seq_state_e               state,
   input  logic [STEP_W-1:0]        step,
   input  logic [BUS_W-1:0]         lane,
   output logic [1:0]               addr,
   output logic [BUS_W-1:0]         data,
   output logic                     cs_n,
   output logic                     wr_n,
   output logic                     upd_n,
   output logic                     clr_n
);
   logic in_write;
   logic strobe;

   assign in_write = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
   assign strobe   = (state == ST_PULSE);

   always_comb begin
      addr  = '0;
      data  = '0;
      cs_n  = 1'b1;
      wr_n  = 1'b1;
      upd_n = 1'b1;
      clr_n = 1'b1;
      if (in_write) begin
         wr_n = !strobe;
         if (step == STEP_W'(UPD_STEP)) begin
            upd_n = !strobe;
         end else begin
            cs_n = 1'b0;
            addr = step[1:0];
            data = lane;
         end
      end else if (state == ST_CLEAR) begin
         clr_n = 1'b0;
      end
   end
endmodule

// File: rtl/dac_bus_sequencer.sv
module dac_bus_sequencer
   import dac_seq_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS = 10000,
   parameter int unsigned ADDR_SETUP_NS = 15,
   parameter int unsigned ADDR_HOLD_NS  = 15,
   parameter int unsigned DATA_SETUP_NS = 60,
   parameter int unsigned DATA_HOLD_NS  = 25,
   parameter int unsigned WR_PULSE_NS   = 80,
   parameter int unsigned CLR_PULSE_NS  = 80,
   parameter int unsigned CHAN_W        = 12,
   parameter int unsigned BUS_W         = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_clear,
   input  logic [CHAN_W-1:0] req_ch_a,
   input  logic [CHAN_W-1:0] req_ch_b,
   output logic              done,
   output logic [1:0]        bus_addr,
   output logic [BUS_W-1:0]  bus_data,
   output logic              bus_cs_n,
   output logic              bus_wr_n,
   output logic              bus_upd_n,
   output logic              bus_clr_n
);
   localparam int unsigned HI_W   = CHAN_W - BUS_W;
   localparam int unsigned SU_CYC = ns_to_cycles(ADDR_SETUP_NS, CLK_PERIOD_PS);
   localparam int unsigned DS_CYC = ns_to_cycles(DATA_SETUP_NS, CLK_PERIOD_PS);
   localparam int unsigned DS_REM = (DS_CYC > SU_CYC) ? DS_CYC - SU_CYC : 1;
   localparam int unsigned PW_CYC = umax(ns_to_cycles(WR_PULSE_NS, CLK_PERIOD_PS), DS_REM);
   localparam int unsigned HD_CYC = umax(ns_to_cycles(ADDR_HOLD_NS, CLK_PERIOD_PS),
                                         ns_to_cycles(DATA_HOLD_NS, CLK_PERIOD_PS));
   localparam int unsigned CL_CYC = ns_to_cycles(CLR_PULSE_NS, CLK_PERIOD_PS);
   localparam int unsigned MAX_CYC = umax(umax(SU_CYC, PW_CYC), umax(HD_CYC, CL_CYC));
   localparam int unsigned CNT_W  = $clog2(MAX_CYC + 1);

   if (CHAN_W <= BUS_W || CHAN_W > 2 * BUS_W) begin : g_bad_width
      $error("channel width must exceed the bus width and fit in two bus beats");
   end
   if (CLK_PERIOD_PS == 0) begin : g_bad_period
      $error("clock period must be non-zero");
   end

   seq_state_e        state;
   logic [STEP_W-1:0] step;
   logic [CHAN_W-1:0] code_a;
   logic [CHAN_W-1:0] code_b;
   logic              t_load;
   logic [CNT_W-1:0]  t_val;
   logic              t_last;
   logic [BUS_W-1:0]  lane;
   logic              take;

   assign req_ready = (state == ST_IDLE);
   assign done      = (state == ST_DONE);
   assign take      = req_ready && req_valid;

   always_comb begin
      t_load = 1'b0;
      t_val  = CNT_W'(SU_CYC);
      case (state)
         ST_IDLE: if (take) begin
            t_load = 1'b1;
            t_val  = req_clear ? CNT_W'(CL_CYC) : CNT_W'(SU_CYC);
         end
         ST_SETUP: if (t_last) begin
            t_load = 1'b1;
            t_val  = CNT_W'(PW_CYC);
         end
         ST_PULSE: if (t_last) begin
            t_load = 1'b1;
            t_val  = CNT_W'(HD_CYC);
         end
         ST_HOLD: if (t_last && step != STEP_W'(UPD_STEP)) begin
            t_load = 1'b1;
            t_val  = CNT_W'(SU_CYC);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         step   <= '0;
         code_a <= '0;
         code_b <= '0;
      end else begin
         case (state)
            ST_IDLE: if (take) begin
               if (req_clear) begin
                  state <= ST_CLEAR;
               end else begin
                  state  <= ST_SETUP;
                  step   <= '0;
                  code_a <= req_ch_a;
                  code_b <= req_ch_b;
               end
            end
            ST_SETUP: if (t_last) state <= ST_PULSE;
            ST_PULSE: if (t_last) state <= ST_HOLD;
            ST_HOLD: if (t_last) begin
               if (step == STEP_W'(UPD_STEP)) begin
                  state <= ST_DONE;
               end else begin
                  step  <= step + 1'b1;
                  state <= ST_SETUP;
               end
            end
            ST_CLEAR: if (t_last) state <= ST_DONE;
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   dac_seq_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .last     (t_last)
   );

   dac_seq_byte_lane #(.CHAN_W(CHAN_W), .BUS_W(BUS_W)) u_lane (
      .ch_a (code_a),
      .ch_b (code_b),
      .sel  (step[1:0]),
      .lane (lane)
   );

   dac_seq_strobe_decode #(.BUS_W(BUS_W)) u_decode (
      .state (state),
      .step  (step),
      .lane  (lane),
      .addr  (bus_addr),
      .data  (bus_data),
      .cs_n  (bus_cs_n),
      .wr_n  (bus_wr_n),
      .upd_n (bus_upd_n),
      .clr_n (bus_clr_n)
   );
endmodule

// File: rtl/dac_seq_checker.sv
module dac_seq_checker #(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned HI_W   = 4,
   parameter int unsigned PW_CYC = 1,
   parameter int unsigned CL_CYC = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             done,
   input logic [1:0]       bus_addr,
   input logic [BUS_W-1:0] bus_data,
   input logic             bus_cs_n,
   input logic             bus_wr_n,
   input logic             bus_upd_n,
   input logic             bus_clr_n
);
   int unsigned wr_lo;
   int unsigned clr_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_lo  <= 0;
         clr_lo <= 0;
      end else begin
         wr_lo  <= bus_wr_n  ? 0 : wr_lo + 1;
         clr_lo <= bus_clr_n ? 0 : clr_lo + 1;
      end
   end

   // R2
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_cs_n && bus_wr_n && bus_upd_n && bus_clr_n));

   // R4
   nibble_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && bus_addr[0]) |-> ((bus_data >> HI_W) == '0));

   // R5
   wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> ($stable(bus_addr) && $stable(bus_data) && $stable(bus_cs_n)));

   // R5
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_wr_n) |-> ($stable(bus_addr) && $stable(bus_data) && $stable(bus_cs_n)));

   // R6
   no_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_cs_n && !bus_upd_n));

   // R6
   upd_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_upd_n |-> !bus_wr_n);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_clr_n |-> (bus_wr_n && bus_cs_n && bus_upd_n));

   // R9
   wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_wr_n) |-> (wr_lo == PW_CYC));

   // R9
   clr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_clr_n) |-> (clr_lo == CL_CYC));
endmodule

bind dac_bus_sequencer dac_seq_checker #(
   .BUS_W  (BUS_W),
   .HI_W   (HI_W),
   .PW_CYC (PW_CYC),
   .CL_CYC (CL_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .done      (done),
   .bus_addr  (bus_addr),
   .bus_data  (bus_data),
   .bus_cs_n  (bus_cs_n),
   .bus_wr_n  (bus_wr_n),
   .bus_upd_n (bus_upd_n),
   .bus_clr_n (bus_clr_n)
);

// File: tb/dac_bus_sequencer_test.sv
module dac_bus_sequencer_test;
   localparam int CW = 12;
   localparam int BW = 8;

   function automatic int cyc(input int ns);
      int c;
      c = (ns * 1000 + 9999) / 10000;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int SU = cyc(15);
   localparam int PW = (cyc(80) > cyc(60) - cyc(15)) ? cyc(80) : cyc(60) - cyc(15);
   localparam int HD = (cyc(15) > cyc(25)) ? cyc(15) : cyc(25);
   localparam int CL = cyc(80);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_clear = 1'b0;
   logic [CW-1:0] req_ch_a = '0;
   logic [CW-1:0] req_ch_b = '0;
   logic          req_ready, done;
   logic [1:0]    bus_addr;
   logic [BW-1:0] bus_data;
   logic          bus_cs_n, bus_wr_n, bus_upd_n, bus_clr_n;

   always #5 clk = ~clk;

   dac_bus_sequencer uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_clear(req_clear), .req_ch_a(req_ch_a), .req_ch_b(req_ch_b), .done(done),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_cs_n(bus_cs_n),
      .bus_wr_n(bus_wr_n), .bus_upd_n(bus_upd_n), .bus_clr_n(bus_clr_n)
   );

   typedef struct {
      int kind;   // 0 write/update strobe, 1 clear pulse
      int addr;
      int data;
      int cs_n;
      int upd_n;
      int su;
      int lo;
      int hd;
   } ev_t;

   ev_t exp_q[$];
   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push_ev(input int kind, input int addr, input int data,
                          input int cs_n, input int upd_n, input int su,
                          input int lo, input int hd);
      ev_t e;
      e.kind = kind; e.addr = addr; e.data = data; e.cs_n = cs_n;
      e.upd_n = upd_n; e.su = su; e.lo = lo; e.hd = hd;
      exp_q.push_back(e);
   endtask

   task automatic compare(input ev_t a);
      ev_t e;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R10 unexpected bus event kind", a.kind, -1);
         return;
      end
      e = exp_q.pop_front();
      chk(a.kind == e.kind, "R8 event kind", a.kind, e.kind);
      if (e.kind == 1) begin
         chk(a.lo == e.lo, "R8 clear low cycles", a.lo, e.lo);
      end else begin
         chk(a.addr == e.addr, "R3 address", a.addr, e.addr);
         chk(a.data == e.data, "R3/R4 data byte", a.data, e.data);
         chk(a.cs_n == e.cs_n, "R6 chip select", a.cs_n, e.cs_n);
         chk(a.upd_n == e.upd_n, "R6 update strobe", a.upd_n, e.upd_n);
         chk(a.su == e.su, "R5 setup cycles", a.su, e.su);
         chk(a.lo == e.lo, "R9 write low cycles", a.lo, e.lo);
         chk(a.hd == e.hd, "R5 hold cycles", a.hd, e.hd);
      end
   endtask

   // Monitor: samples on the falling edge, away from the active edge.
   initial begin
      bit   in_low = 0, in_hold = 0, in_clr = 0;
      int   su_run = 0, p_addr = 0, p_data = 0, p_cs = 1;
      ev_t  cur;
      int   clr_run = 0;
      cur = '{0, 0, 0, 1, 1, 0, 0, 0};
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (!bus_wr_n) begin
               if (!in_low) begin
                  in_low = 1;
                  cur.kind = 0; cur.addr = bus_addr; cur.data = bus_data;
                  cur.cs_n = bus_cs_n; cur.upd_n = bus_upd_n;
                  cur.su = (bus_addr == p_addr && bus_data == p_data && bus_cs_n == p_cs) ? su_run : 0;
                  cur.lo = 1;
               end else begin
                  cur.lo++;
               end
            end else begin
               if (in_low) begin
                  in_low = 0;
                  in_hold = 1;
                  cur.hd = 0;
               end
               if (in_hold) begin
                  if (done || bus_addr != cur.addr || bus_data != cur.data || bus_cs_n != cur.cs_n) begin
                     in_hold = 0;
                     compare(cur);
                  end else begin
                     cur.hd++;
                  end
               end
               if (req_ready || done) su_run = 0;
               else if (bus_addr == p_addr && bus_data == p_data && bus_cs_n == p_cs) su_run++;
               else su_run = 1;
            end
            if (!bus_clr_n) begin
               in_clr = 1;
               clr_run++;
            end else if (in_clr) begin
               ev_t c;
               c = '{1, 0, 0, 1, 1, 0, clr_run, 0};
               in_clr = 0;
               clr_run = 0;
               compare(c);
            end
            p_addr = bus_addr; p_data = bus_data; p_cs = bus_cs_n;
         end
      end
   end

   // Driver: pushes the expected bus events, then issues the request.
   task automatic send(input bit clr, input logic [CW-1:0] a, input logic [CW-1:0] b,
                       input bit hold_busy);
      int n;
      int exp_n;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      if (clr) begin
         push_ev(1, 0, 0, 1, 1, 0, CL, 0);
         exp_n = CL;
      end else begin
         push_ev(0, 0, int'(a[7:0]), 0, 1, SU, PW, HD);
         push_ev(0, 1, int'(a[11:8]), 0, 1, SU, PW, HD);
         push_ev(0, 2, int'(b[7:0]), 0, 1, SU, PW, HD);
         push_ev(0, 3, int'(b[11:8]), 0, 1, SU, PW, HD);
         push_ev(0, 0, 0, 1, 0, SU, PW, HD);
         exp_n = 5 * (SU + PW + HD);
      end
      req_valid = 1'b1;
      req_clear = clr;
      req_ch_a  = a;
      req_ch_b  = b;
      @(negedge clk);
      chk(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
      if (hold_busy) begin
         req_ch_a = ~a;
         req_ch_b = ~b;
         req_clear = 1'b0;
      end else begin
         req_valid = 1'b0;
      end
      n = 0;
      while (!done) begin
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      chk(n == exp_n, "R7 cycles to done", n, exp_n);
      @(negedge clk);
      chk(done == 1'b0, "R7 done is one cycle", done, 0);
      chk(req_ready == 1'b1, "R7 ready after done", req_ready, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
      chk(done == 1'b0, "R1 done in reset", done, 0);
      chk({bus_cs_n, bus_wr_n, bus_upd_n, bus_clr_n} == 4'b1111, "R1 strobes idle",
          {bus_cs_n, bus_wr_n, bus_upd_n, bus_clr_n}, 15);
      chk(bus_addr == 0 && bus_data == 0, "R1 address and data zero", bus_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({bus_cs_n, bus_wr_n, bus_upd_n, bus_clr_n} == 4'b1111, "R1 idle after reset",
          {bus_cs_n, bus_wr_n, bus_upd_n, bus_clr_n}, 15);

      send(1'b0, 12'hABC, 12'h123, 1'b0);   // R3 R4 R5 R6
      send(1'b0, 12'h000, 12'hFFF, 1'b0);   // R4 zero low byte, full nibble
      send(1'b1, 12'h777, 12'h777, 1'b0);   // R8 clear ignores codes
      send(1'b0, 12'hF0F, 12'h0F0, 1'b0);   // load directly after clear
      send(1'b0, 12'h5A5, 12'hA5A, 1'b1);   // R10 request held while busy
      // R10: with the held request dropped, the bus stays idle
      repeat (20) begin
         @(negedge clk);
         if (!bus_cs_n || !bus_wr_n || !bus_upd_n || !bus_clr_n) begin
            chk(1'b0, "R10 bus idle after held request", 0, 1);
         end
      end
      chk(bus_cs_n && bus_wr_n && bus_upd_n && bus_clr_n, "R10 bus idle after held request", 0, 0);
      send(1'b0, 12'hFFF, 12'h000, 1'b0);   // R9 timing at opposite codes
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R3 all expected events seen", exp_q.size(), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule